// File: doc/BRIEF.md
# Memory Array Controller Configuration and Error Registers

This block is the software-visible register face of a DRAM array controller. A bus master issues single longword requests (a byte address, a length code, a write flag and write data). The block decodes the longword offset into four 32-bit registers and a small read-only ROM window. It answers every request one cycle later with a response code and read data. Register A holds the array size, type and interleave setting. Register B holds the start address and diagnostic check bits. Registers C and D hold sticky error flags, which are set from outside and cleared by writing ones.

Two controller flavours are built from one source through the `EXT_VARIANT` parameter. The basic flavour has no register D and a narrow error-clear set. The extended flavour adds register D and widens the clearable and visible error bits. Reset values follow from the flavour, the array size in megabytes and the controller's position on the bus. The ROM contents are written one byte at a time through a side load port. Bus writes cannot change the ROM.

Top module: `memctl_regfile`

## Requirements
- R1: Longword offset (address bits above 1) 0 selects A, 1 selects B, 2 selects C and 3 selects D. Every offset from 0x400 upward reads the ROM word indexed by (offset − 0x400) modulo the ROM depth.
- R2: A request whose address bits 1:0 are not zero, or whose length code is not 2 (the longword code; 0 and 1 are byte and word, 3 is reserved), changes no register. It answers with code 2 (error-confirm), read data 0, and `err_confirm` high for that one response cycle.
- R3: A reads as its stored value ANDed with 0x00107FFF, with `flt_status` placed at bits 27:24. A write always stores bit 8. It stores bits 2:0 only if bit 8 of the same write data is 1.
- R4: B reads as its stored value ANDed with 0xFFFFF7FF, with bits 13:12 forced to 1. A write always stores bits 9:0 and bit 14. It stores bits 27:15 only if bit 14 of the same write data is 1.
- R5: In C and D, bit 30 is plain read/write. A 1 written to a clearable bit clears it, and a 0 leaves it alone. The clearable set is 0x30000000 in the basic flavour and 0x300C0380 in the extended one.
- R6: C reads through mask 0x7FFFFFFF in the basic flavour and 0x700C0380 in the extended one. D reads through 0x700C0380.
- R7: The response is code 1 (nonexistent) with read data 0 and no register change in three cases: offset 3 in the basic flavour, offsets 4 to 0x3FF, and any write at offset 0x400 or above.
- R8: After reset, C and D are 0. The basic flavour sets A = 0x7E10 and B = 0x3000 | (index << 21). The extended flavour sets A = ((size_MB − 1) << 9) | 0x6A and B = 0x3000 | ((index × size_MB) << 19).
- R9: A load-port strobe replaces the byte lane chosen by `rom_ld_addr[1:0]` in the ROM word chosen by the upper load-address bits. The other three lanes keep their values.
- R10: Each cycle, `err_set_c`/`err_set_d` are ORed into the clearable bits of C/D (D only in the extended flavour). Other bits of those inputs are ignored. A set wins over a write-one-to-clear of the same bit in the same cycle.
- R11: `rsp_valid` is high exactly one cycle after each request cycle and low otherwise. Code 0 means OK. Read data is 0 for writes and for non-OK responses, and reads return values from before the request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the block |
| req_len | input | 2 | Length code, 2 = longword |
| req_wdata | input | 32 | Write data |
| flt_status | input | 4 | Live bus-fault flags shown in A |
| err_set_c | input | 32 | Sticky error set for C |
| err_set_d | input | 32 | Sticky error set for D |
| rom_ld_en | input | 1 | ROM byte load strobe |
| rom_ld_addr | input | ROM_AW+2 | ROM byte address for loading |
| rom_ld_byte | input | 8 | Byte to load |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 1 nonexistent, 2 error-confirm |
| rsp_rdata | output | 32 | Read data |
| err_confirm | output | 1 | Bad-access pulse |

## Verification
Corrupt register state stays hidden until the next read of that offset. That read then exposes it on `rsp_rdata` one cycle after the request. For the clear, set and gating rules, that read is the very next request. A decode fault shows at once as a wrong `rsp_code` on the following cycle. A missing reset value appears on the first read after reset. A ROM lane error appears only when the word is read back. Two instances, one per flavour, see the same stimulus, so every mask difference is compared against its own model on each response.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_NXM    = 2'd1,
        RSP_ERRCNF = 2'd2
    } rsp_code_e;

    typedef enum logic [2:0] {
        SEL_A, SEL_B, SEL_C, SEL_D, SEL_ROM, SEL_NONE, SEL_BAD
    } sel_e;

    localparam logic [1:0]  LEN_LONG      = 2'd2;
    localparam int          ROM_BASE      = 32'h400;
    localparam int          FLT_LSB       = 24;

    localparam logic [31:0] A_RD_MASK     = 32'h0010_7FFF;
    localparam logic [31:0] A_WR_FIXED    = 32'h0000_0100;
    localparam logic [31:0] A_ILV_FIELD   = 32'h0000_0007;
    localparam int          A_ILV_EN      = 8;
    localparam logic [31:0] A_SIZE_BASIC  = 32'h0000_7E00;
    localparam logic [31:0] A_TYPE_BASIC  = 32'h0000_0010;
    localparam logic [31:0] A_TYPE_EXT    = 32'h0000_006A;

    localparam logic [31:0] B_RD_MASK     = 32'hFFFF_F7FF;
    localparam logic [31:0] B_FORCE_ONES  = 32'h0000_3000;
    localparam logic [31:0] B_WR_FIXED    = 32'h0000_43FF;
    localparam logic [31:0] B_START_FIELD = 32'h0FFF_8000;
    localparam int          B_START_EN    = 14;

    localparam logic [31:0] CD_RW_BIT     = 32'h4000_0000;
    localparam logic [31:0] CLR_BASIC     = 32'h3000_0000;
    localparam logic [31:0] CLR_EXT       = 32'h300C_0380;
    localparam logic [31:0] C_RD_BASIC    = 32'h7FFF_FFFF;
    localparam logic [31:0] CD_RD_EXT     = 32'h700C_0380;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
        logic        rsp_valid;
        logic [1:0]  code;
        logic [31:0] rdata;
        logic        errcnf;
    } regs_t;

endpackage

// File: rtl/memctl_decode.sv
module memctl_decode
    import memctl_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter bit EXT_VARIANT = 1'b0,
    parameter int ROM_AW      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len,
    output sel_e              sel,
    output logic [ROM_AW-1:0] rom_idx
);
    localparam int OFS_W = ADDR_W - 2;

    logic [OFS_W-1:0] ofs;
    logic [31:0]      ofs32;
    logic [31:0]      rom_rel;

    assign ofs     = addr[ADDR_W-1:2];
    assign ofs32   = 32'(ofs);
    assign rom_rel = ofs32 - 32'(ROM_BASE);
    assign rom_idx = rom_rel[ROM_AW-1:0];

    always_comb begin
        if (addr[1:0] != 2'b00 || len != LEN_LONG) begin
            sel = SEL_BAD;
        end else if (ofs32 >= 32'(ROM_BASE)) begin
            sel = SEL_ROM;
        end else begin
            case (ofs32)
                32'd0:   sel = SEL_A;
                32'd1:   sel = SEL_B;
                32'd2:   sel = SEL_C;
                32'd3:   sel = EXT_VARIANT ? SEL_D : SEL_NONE;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/memctl_rom.sv
module memctl_rom #(
    parameter int ROM_WORDS = 16,
    parameter int ROM_AW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ROM_AW+1:0] ld_addr,
    input  logic [7:0]        ld_byte,
    input  logic [ROM_AW-1:0] rd_idx,
    output logic [31:0]       rd_data
);
    logic [31:0] word_q [ROM_WORDS];

    for (genvar w = 0; w < ROM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = ld_en && (ld_addr[ROM_AW+1:2] == ROM_AW'(w));
        for (genvar ln = 0; ln < 4; ln++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[w][ln*8 +: 8] <= 8'h00;
                end else if (hit && ld_addr[1:0] == 2'(ln)) begin
                    word_q[w][ln*8 +: 8] <= ld_byte;
                end
            end
        end
    end

    assign rd_data = word_q[rd_idx];

    // R9
    lane_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> $countones(word_q[$past(ld_addr[ROM_AW+1:2])] ^
                             $past(word_q[ld_addr[ROM_AW+1:2]])) <= 8);
endmodule

// File: rtl/memctl_regfile.sv
module memctl_regfile
    import memctl_pkg::*;
#(
    parameter bit EXT_VARIANT = 1'b0,
    parameter int CTRL_INDEX  = 0,
    parameter int ARRAY_MB    = 4,
    parameter int ROM_WORDS   = 16,
    parameter int ADDR_W      = 13,
    localparam int ROM_AW     = $clog2(ROM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        flt_status,
    input  logic [31:0]       err_set_c,
    input  logic [31:0]       err_set_d,
    input  logic              rom_ld_en,
    input  logic [ROM_AW+1:0] rom_ld_addr,
    input  logic [7:0]        rom_ld_byte,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [31:0]       rsp_rdata,
    output logic              err_confirm
);
    localparam logic [31:0] CLR_SET = EXT_VARIANT ? CLR_EXT : CLR_BASIC;
    localparam logic [31:0] C_RD    = EXT_VARIANT ? CD_RD_EXT : C_RD_BASIC;
    localparam logic [31:0] A_RST   = EXT_VARIANT
        ? ((32'(ARRAY_MB - 1) << 9) | A_TYPE_EXT)
        : (A_SIZE_BASIC | A_TYPE_BASIC);
    localparam logic [31:0] B_RST   = EXT_VARIANT
        ? (B_FORCE_ONES | (32'(CTRL_INDEX * ARRAY_MB) << 19))
        : (B_FORCE_ONES | (32'(CTRL_INDEX) << 21));
    localparam regs_t RST_STATE = '{a: A_RST, b: B_RST, c: 32'h0, d: 32'h0,
                                    rsp_valid: 1'b0, code: 2'd0,
                                    rdata: 32'h0, errcnf: 1'b0};

    sel_e              sel;
    logic [ROM_AW-1:0] rom_idx;
    logic [31:0]       rom_word;
    regs_t             s_d, s_q;

    memctl_decode #(.ADDR_W(ADDR_W), .EXT_VARIANT(EXT_VARIANT), .ROM_AW(ROM_AW)) u_decode (
        .addr    (req_addr),
        .len     (req_len),
        .sel     (sel),
        .rom_idx (rom_idx)
    );

    memctl_rom #(.ROM_WORDS(ROM_WORDS), .ROM_AW(ROM_AW)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (rom_ld_en),
        .ld_addr (rom_ld_addr),
        .ld_byte (rom_ld_byte),
        .rd_idx  (rom_idx),
        .rd_data (rom_word)
    );

    always_comb begin
        logic [31:0] wmask;
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.code      = RSP_OK;
        s_d.rdata     = 32'h0;
        s_d.errcnf    = 1'b0;
        wmask         = 32'h0;
        if (req_valid) begin
            case (sel)
                SEL_BAD: begin
                    s_d.code   = RSP_ERRCNF;
                    s_d.errcnf = 1'b1;
                end
                SEL_NONE: s_d.code = RSP_NXM;
                SEL_ROM: begin
                    if (req_write) s_d.code  = RSP_NXM;
                    else           s_d.rdata = rom_word;
                end
                SEL_A: begin
                    if (req_write) begin
                        wmask = A_WR_FIXED | (req_wdata[A_ILV_EN] ? A_ILV_FIELD : 32'h0);
                        s_d.a = (s_q.a & ~wmask) | (req_wdata & wmask);
                    end else begin
                        s_d.rdata = (s_q.a & A_RD_MASK) | (32'(flt_status) << FLT_LSB);
                    end
                end
                SEL_B: begin
                    if (req_write) begin
                        wmask = B_WR_FIXED | (req_wdata[B_START_EN] ? B_START_FIELD : 32'h0);
                        s_d.b = (s_q.b & ~wmask) | (req_wdata & wmask);
                    end else begin
                        s_d.rdata = (s_q.b & B_RD_MASK) | B_FORCE_ONES;
                    end
                end
                SEL_C: begin
                    if (req_write)
                        s_d.c = ((s_q.c & ~CD_RW_BIT) | (req_wdata & CD_RW_BIT))
                                & ~(req_wdata & CLR_SET);
                    else
                        s_d.rdata = s_q.c & C_RD;
                end
                SEL_D: begin
                    if (req_write)
                        s_d.d = ((s_q.d & ~CD_RW_BIT) | (req_wdata & CD_RW_BIT))
                                & ~(req_wdata & CLR_SET);
                    else
                        s_d.rdata = s_q.d & CD_RD_EXT;
                end
                default: s_d.code = RSP_NXM;
            endcase
        end
        s_d.c = s_d.c | (err_set_c & CLR_SET);
        if (EXT_VARIANT) s_d.d = s_d.d | (err_set_d & CLR_SET);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign rsp_valid   = s_q.rsp_valid;
    assign rsp_code    = s_q.code;
    assign rsp_rdata   = s_q.rdata;
    assign err_confirm = s_q.errcnf;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    bad_access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel == SEL_BAD) |=> ($stable(s_q.a) && $stable(s_q.b)));
    // R2
    errcnf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_confirm |-> (rsp_valid && rsp_code == RSP_ERRCNF));
    // R4
    b_force_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel == SEL_B) |=> (rsp_rdata[13:12] == 2'b11));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_set_c & CLR_SET)) |=>
            ((s_q.c & $past(err_set_c & CLR_SET)) == $past(err_set_c & CLR_SET)));

    if (!EXT_VARIANT) begin : g_basic_chk
        // R7
        no_reg_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_addr[1:0] == 2'b00 && req_len == LEN_LONG &&
             req_addr[ADDR_W-1:2] == 3) |=> (rsp_code == RSP_NXM));
    end
endmodule

// File: tb/memctl_regfile_bench.sv
module memctl_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_B = 1;
    localparam int MB_B  = 4;
    localparam int IDX_E = 2;
    localparam int MB_E  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [1:0]  req_len = 2'd2;
    logic [31:0] req_wdata = '0, err_set_c = '0, err_set_d = '0;
    logic [3:0]  flt_status = '0;
    logic        rom_ld_en = 1'b0;
    logic [5:0]  rom_ld_addr = '0;
    logic [7:0]  rom_ld_byte = '0;
    logic        rv [2];
    logic [1:0]  rc [2];
    logic [31:0] rd [2];
    logic        ec [2];

    int checks = 0, fails = 0;
    logic [31:0] m_a [2], m_b [2], m_c [2], m_d [2];
    logic [31:0] m_rom [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    memctl_regfile #(.EXT_VARIANT(1'b0), .CTRL_INDEX(IDX_B), .ARRAY_MB(MB_B)) u_memctl_regfile (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_len, .req_wdata,
        .flt_status, .err_set_c, .err_set_d, .rom_ld_en, .rom_ld_addr, .rom_ld_byte,
        .rsp_valid(rv[0]), .rsp_code(rc[0]), .rsp_rdata(rd[0]), .err_confirm(ec[0]));

    memctl_regfile #(.EXT_VARIANT(1'b1), .CTRL_INDEX(IDX_E), .ARRAY_MB(MB_E)) u_memctl_regfile_ext (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_len, .req_wdata,
        .flt_status, .err_set_c, .err_set_d, .rom_ld_en, .rom_ld_addr, .rom_ld_byte,
        .rsp_valid(rv[1]), .rsp_code(rc[1]), .rsp_rdata(rd[1]), .err_confirm(ec[1]));

    function automatic logic [31:0] clr_of(int v);
        return (v == 1) ? 32'h300C0380 : 32'h30000000;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] exp_rsp(int v, logic wr, logic [12:0] addr,
                                            logic [1:0] len, logic [3:0] flt);
        logic [10:0] ofs = addr[12:2];
        if (addr[1:0] != 2'b00 || len != 2'd2) return {2'd2, 32'h0};
        if (ofs >= 11'h400) return wr ? {2'd1, 32'h0} : {2'd0, m_rom[4'(ofs - 11'h400)]};
        case (ofs)
            11'd0: return {2'd0, wr ? 32'h0 : ((m_a[v] & 32'h00107FFF) | (32'(flt) << 24))};
            11'd1: return {2'd0, wr ? 32'h0 : ((m_b[v] & 32'hFFFFF7FF) | 32'h3000)};
            11'd2: return {2'd0, wr ? 32'h0 : (m_c[v] & ((v == 1) ? 32'h700C0380 : 32'h7FFFFFFF))};
            11'd3: if (v == 1) return {2'd0, wr ? 32'h0 : (m_d[v] & 32'h700C0380)};
                   else return {2'd1, 32'h0};
            default: return {2'd1, 32'h0};
        endcase
    endfunction

    function automatic void model_apply(int v, logic wr, logic [12:0] addr, logic [1:0] len,
                                        logic [31:0] wd, logic [31:0] sc, logic [31:0] sd);
        logic [31:0] clr = clr_of(v);
        logic [31:0] m;
        logic [10:0] ofs = addr[12:2];
        if (wr && addr[1:0] == 2'b00 && len == 2'd2) begin
            case (ofs)
                11'd0: begin m = 32'h100 | (wd[8] ? 32'h7 : 32'h0);
                             m_a[v] = (m_a[v] & ~m) | (wd & m); end
                11'd1: begin m = 32'h43FF | (wd[14] ? 32'h0FFF8000 : 32'h0);
                             m_b[v] = (m_b[v] & ~m) | (wd & m); end
                11'd2: m_c[v] = ((m_c[v] & ~32'h40000000) | (wd & 32'h40000000)) & ~(wd & clr);
                11'd3: if (v == 1)
                           m_d[v] = ((m_d[v] & ~32'h40000000) | (wd & 32'h40000000)) & ~(wd & clr);
                default: ;
            endcase
        end
        m_c[v] = m_c[v] | (sc & clr);
        if (v == 1) m_d[v] = m_d[v] | (sd & clr);
    endfunction

    task automatic req(input string tag, input logic wr, input logic [12:0] addr,
                       input logic [1:0] len, input logic [31:0] wd,
                       input logic [31:0] sc, input logic [31:0] sd);
        logic [33:0] e [2];
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len;
        req_wdata = wd; err_set_c = sc; err_set_d = sd;
        flt_status = 4'($urandom);
        for (int v = 0; v < 2; v++) e[v] = exp_rsp(v, wr, addr, len, flt_status);
        @(negedge clk);
        for (int v = 0; v < 2; v++) begin
            check({tag, " valid"}, 64'(rv[v]), 64'd1);
            check({tag, " code/data"}, 64'({rc[v], rd[v]}), 64'(e[v]));
            check({tag, " R2 errcnf"}, 64'(ec[v]), 64'(e[v][33:32] == 2'd2));
            model_apply(v, wr, addr, len, wd, sc, sd);
        end
        req_valid = 1'b0; err_set_c = '0; err_set_d = '0;
    endtask

    task automatic rd_reg(input string tag, input int ofs);
        req(tag, 1'b0, 13'(ofs << 2), 2'd2, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic wr_reg(input string tag, input int ofs, input logic [31:0] wd);
        req(tag, 1'b1, 13'(ofs << 2), 2'd2, wd, 32'h0, 32'h0);
    endtask

    task automatic rom_load(input logic [5:0] a, input logic [7:0] b);
        rom_ld_en = 1'b1; rom_ld_addr = a; rom_ld_byte = b;
        @(negedge clk);
        rom_ld_en = 1'b0;
        m_rom[a[5:2]][a[1:0]*8 +: 8] = b;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_a[0] = 32'h7E10;                       m_b[0] = 32'h3000 | (32'(IDX_B) << 21);
        m_a[1] = (32'(MB_E - 1) << 9) | 32'h6A;  m_b[1] = 32'h3000 | (32'(IDX_E * MB_E) << 19);
        for (int v = 0; v < 2; v++) begin m_c[v] = 0; m_d[v] = 0; end
        for (int i = 0; i < 16; i++) m_rom[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 2; v++) check("R11 idle after reset", 64'(rv[v]), 64'd0);
        for (int o = 0; o < 4; o++) rd_reg("R8 reset value", o);

        // R3 interleave gate
        wr_reg("R3 write no enable", 0, 32'hFFFF_FEFF);
        rd_reg("R3 readback", 0);
        wr_reg("R3 write enable", 0, 32'h0000_0105);
        rd_reg("R3 readback gated", 0);
        // R4 start address gate
        wr_reg("R4 write no enable", 1, 32'hFFFF_BFFF);
        rd_reg("R4 readback", 1);
        wr_reg("R4 write enable", 1, 32'h0ABC_C2AA);
        rd_reg("R4 readback gated", 1);
        // R5 R6 clear rules and read masks
        req("R10 set all", 1'b0, 13'd8, 2'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_reg("R6 C after set", 2);
        rd_reg("R6 D after set", 3);
        wr_reg("R5 C write zero", 2, 32'h4000_0000);
        rd_reg("R5 C hold", 2);
        wr_reg("R5 C clear", 2, 32'h3008_0100);
        rd_reg("R5 C partial clear", 2);
        wr_reg("R5 D clear", 3, 32'hFFFF_FFFF);
        rd_reg("R5 D clear", 3);
        // R10 set wins over clear
        req("R10 collide", 1'b1, 13'd8, 2'd2, 32'hFFFF_FFFF, 32'h1004_0080, 32'h0);
        rd_reg("R10 set wins", 2);
        // R7 nonexistent offsets
        wr_reg("R7 unused write", 5, 32'hFFFF_FFFF);
        rd_reg("R7 unused read", 12'h3FF);
        req("R7 rom write", 1'b1, 13'h1000, 2'd2, 32'hDEAD_BEEF, 0, 0);
        // R2 bad accesses
        req("R2 misaligned", 1'b1, 13'h0002, 2'd2, 32'hFFFF_FFFF, 0, 0);
        req("R2 short", 1'b1, 13'h0004, 2'd1, 32'hFFFF_FFFF, 0, 0);
        rd_reg("R2 A unchanged", 0);
        rd_reg("R2 B unchanged", 1);
        // R9 R1 ROM lanes
        rom_load(6'h05, 8'hA5);
        rom_load(6'h06, 8'h3C);
        rd_reg("R9 rom lane", 12'h401);
        rom_load(6'h05, 8'h11);
        rd_reg("R9 rom lane replace", 12'h401);
        rd_reg("R1 rom alias", 12'h411);
        @(negedge clk);
        for (int v = 0; v < 2; v++) check("R11 idle", 64'(rv[v]), 64'd0);

        for (int it = 0; it < 800; it++) begin
            int k = int'($urandom % 8);
            logic [31:0] wd = $urandom;
            logic [31:0] sc = ($urandom % 4 == 0) ? $urandom : 32'h0;
            logic [31:0] sd = ($urandom % 4 == 0) ? $urandom : 32'h0;
            case (k)
                0: req("R1 rnd read", 1'b0, 13'(($urandom % 4) << 2), 2'd2, 0, sc, sd);
                1, 2: req("R3 R4 R5 rnd write", 1'b1, 13'(($urandom % 4) << 2), 2'd2, wd, sc, sd);
                3: begin
                    logic [12:0] a = 13'($urandom);
                    logic [1:0]  l = 2'($urandom);
                    if (a[1:0] == 0 && l == 2) l = 2'd0;
                    req("R2 rnd bad", 1'($urandom), a, l, wd, sc, sd);
                end
                4: req("R7 rnd unused", 1'($urandom), 13'((4 + $urandom % 12'h3FC) << 2), 2'd2, wd, sc, sd);
                5: req("R1 rnd rom", 1'b0, 13'((12'h400 + $urandom % 12'h400) << 2), 2'd2, 0, sc, sd);
                6: req("R7 rnd rom write", 1'b1, 13'((12'h400 + $urandom % 12'h400) << 2), 2'd2, wd, sc, sd);
                default: rom_load(6'($urandom), 8'($urandom));
            endcase
        end
        finish_run();
    end
endmodule